// File: doc/BRIEF.md
# Time-Slot Octet Capture with Slip Control

This block takes one octet per frame from a 2.048 Mbit/s serial PCM stream and hands it across to a slower 64 kbit/s line side that runs from its own clock. A two-input multiplexer chooses which of two time-slot envelopes is used. While that envelope is high, serial bits are shifted into an 8-bit register on each bit-clock tick. A complete octet is parked in a holding register. Its completion is then carried into the line side, where the octet is written into a storage latch.

The line encoder asks for its next octet with a one-cycle request pulse. One cycle later the block answers with a valid pulse, the octet, and two flags.

The two clock rates can drift against each other, so the handoff slips by whole octets:
- If nothing new has arrived since the last transfer, the last octet is repeated once.
- If a second request still finds no new octet, the answer is idle, and the encoder holds its line outputs high.
- An octet that arrives while an earlier one is still waiting in the latch replaces it, and the earlier one is lost.

Both clock domains are modelled as clock enables and synchronisers on one fast system clock.

Top module: `slot_slip_top`

## Requirements
- R1: When `slot_sel` is 1 the envelope `slot_a` is used, and when it is 0 the envelope `slot_b` is used. Bits that arrive under the unselected envelope are never captured.
- R2: On each `bit_en` cycle with the selected envelope high, `pcm_in` is shifted in. The first bit of a window becomes bit 7 of the octet. The eighth bit completes the octet.
- R3: A `bit_en` cycle with the selected envelope low discards a partly filled octet and restarts the count.
- R4: `oct_valid` is high in exactly the cycles that follow a cycle with `oct_req` high.
- R5: A request that finds a stored octet not yet transferred returns that octet with `oct_repeat`=0 and `oct_idle`=0.
- R6: A request that finds no new octet, and whose last octet has not been repeated yet, returns the last octet again with `oct_repeat`=1.
- R7: A request after the single repeat, with still no new octet, returns `oct_idle`=1 and `oct_repeat`=0. The same holds for any request made before the first octet after reset.
- R8: An octet completed while the previous one is still untransferred overwrites it. The next request returns only the newer octet.
- R9: After reset `oct_valid`, `oct_repeat` and `oct_idle` are 0.
- R10: A request sampled at the third clock edge after the edge that took the eighth bit, or later, receives the new octet as a fresh transfer. This includes the edge where the octet lands in the latch. A request sampled at the first or second such edge sees the old state.
- R11: `oct_repeat` and `oct_idle` are never both 1. Every octet returned equals a whole captured octet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock shared by both modelled domains |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle tick marking a rising edge of the 2.048 MHz bit clock |
| pcm_in | input | 1 | Serial PCM data |
| slot_a | input | 1 | First time-slot envelope |
| slot_b | input | 1 | Second time-slot envelope |
| slot_sel | input | 1 | Envelope select: 1 uses slot_a, 0 uses slot_b |
| oct_req | input | 1 | Line side requests its next octet |
| oct_valid | output | 1 | Response strobe, one cycle after a request |
| oct_data | output | 8 | Octet handed to the line side |
| oct_repeat | output | 1 | Response is a repeat of the previous octet |
| oct_idle | output | 1 | No data: line outputs are to be held high |

## Verification
The handoff must decide correctly when the arrival of a new octet in the latch and a line-side request fall on the same clock edge. In that case the incoming octet is passed straight through as a fresh transfer.

The bench finishes an octet and then places a request at each offset from one to seven edges after the final bit. It computes from the crossing latency of three edges whether the first answer must be a repeat of the older octet or the new octet. It then checks that the following answers form the correct fresh/repeat/idle sequence, with no octet lost or duplicated beyond the single allowed repeat.

// File: rtl/slot_slip_pkg.sv
package slot_slip_pkg;
    localparam int OCT_W   = 8;
    localparam int CNT_W   = $clog2(OCT_W);
    localparam int SYNC_N  = 2;
endpackage

// File: rtl/slot_capture.sv
module slot_capture #(
    parameter int W     = slot_slip_pkg::OCT_W,
    localparam int CW   = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         pcm_in,
    input  logic         slot_a,
    input  logic         slot_b,
    input  logic         slot_sel,
    output logic [W-1:0] hold,
    output logic         done_tgl
);
    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
        logic [W-1:0]  hold;
        logic          tgl;
    } cap_t;

    cap_t st_q, st_d;
    logic slot_on;
    logic [W-1:0] sh_next;

    always_comb begin
        st_d    = st_q;
        slot_on = slot_sel ? slot_a : slot_b;
        sh_next = {st_q.sh[W-2:0], pcm_in};
        if (bit_en) begin
            if (slot_on) begin
                st_d.sh = sh_next;
                if (st_q.cnt == CW'(W-1)) begin
                    st_d.cnt  = '0;
                    st_d.hold = sh_next;
                    st_d.tgl  = ~st_q.tgl;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold     = st_q.hold;
    assign done_tgl = st_q.tgl;
endmodule

// File: rtl/event_sync.sv
module event_sync #(
    parameter int STAGES = slot_slip_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic evt
);
    logic [STAGES:0] chain_q, chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = {chain_q[0], tgl_in};
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-1:0], tgl_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign evt = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/slip_ctrl.sv
module slip_ctrl #(
    parameter int W = slot_slip_pkg::OCT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic [W-1:0] hold,
    input  logic         req,
    output logic         valid,
    output logic [W-1:0] data,
    output logic         rep,
    output logic         idle
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic         fresh;
        logic         used;
        logic         valid;
        logic [W-1:0] data;
        logic         rep;
        logic         idle;
    } slip_t;

    slip_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.rep   = 1'b0;
        st_d.idle  = 1'b0;
        if (evt) begin
            st_d.latch = hold;
            st_d.fresh = 1'b1;
            st_d.used  = 1'b0;
        end
        if (req) begin
            st_d.valid = 1'b1;
            if (evt) begin
                st_d.data  = hold;
                st_d.fresh = 1'b0;
            end else if (st_q.fresh) begin
                st_d.data  = st_q.latch;
                st_d.fresh = 1'b0;
            end else if (!st_q.used) begin
                st_d.data = st_q.latch;
                st_d.rep  = 1'b1;
                st_d.used = 1'b1;
            end else begin
                st_d.idle = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.used <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign data  = st_q.data;
    assign rep   = st_q.rep;
    assign idle  = st_q.idle;
endmodule

// File: rtl/slot_slip_top.sv
module slot_slip_top #(
    parameter int W      = slot_slip_pkg::OCT_W,
    parameter int STAGES = slot_slip_pkg::SYNC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         pcm_in,
    input  logic         slot_a,
    input  logic         slot_b,
    input  logic         slot_sel,
    input  logic         oct_req,
    output logic         oct_valid,
    output logic [W-1:0] oct_data,
    output logic         oct_repeat,
    output logic         oct_idle
);
    logic [W-1:0] cap_hold;
    logic         cap_tgl;
    logic         cap_evt;

    slot_capture #(.W(W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .pcm_in   (pcm_in),
        .slot_a   (slot_a),
        .slot_b   (slot_b),
        .slot_sel (slot_sel),
        .hold     (cap_hold),
        .done_tgl (cap_tgl)
    );

    event_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tgl_in (cap_tgl),
        .evt    (cap_evt)
    );

    slip_ctrl #(.W(W)) u_slip (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (cap_evt),
        .hold  (cap_hold),
        .req   (oct_req),
        .valid (oct_valid),
        .data  (oct_data),
        .rep   (oct_repeat),
        .idle  (oct_idle)
    );
endmodule

// File: rtl/slot_slip_chk.sv
module slot_slip_chk (
    input logic clk,
    input logic rst_n,
    input logic oct_req,
    input logic oct_valid,
    input logic oct_repeat,
    input logic oct_idle,
    input logic evt
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      armed_q <= 1'b0;
        else if (evt)                    armed_q <= 1'b1;
        else if (oct_valid && oct_repeat) armed_q <= 1'b0;
    end

    a_r4_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        oct_req |=> oct_valid);

    a_r4_no_unrequested_valid: assert property (@(posedge clk) disable iff (!rst_n)
        oct_valid |-> $past(oct_req));

    a_r6_single_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && oct_repeat) |-> armed_q);

    a_r7_idle_only_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && oct_idle) |-> !armed_q);

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(oct_repeat && oct_idle));

    a_r10_event_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    a_r9_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_repeat || oct_idle) |-> oct_valid);
endmodule

bind slot_slip_top slot_slip_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oct_req    (oct_req),
    .oct_valid  (oct_valid),
    .oct_repeat (oct_repeat),
    .oct_idle   (oct_idle),
    .evt        (cap_evt)
);

// File: tb/slot_slip_top_tb.sv
module slot_slip_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       pcm_in = 1'b0;
    logic       slot_a = 1'b0;
    logic       slot_b = 1'b0;
    logic       slot_sel = 1'b1;
    logic       oct_req = 1'b0;
    logic       oct_valid;
    logic [7:0] oct_data;
    logic       oct_repeat;
    logic       oct_idle;

    int checks = 0;
    int errors = 0;

    localparam int K_FRESH = 0;
    localparam int K_REP   = 1;
    localparam int K_IDLE  = 2;

    always #5 clk = ~clk;

    slot_slip_top u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pcm_in(pcm_in),
        .slot_a(slot_a), .slot_b(slot_b), .slot_sel(slot_sel),
        .oct_req(oct_req), .oct_valid(oct_valid), .oct_data(oct_data),
        .oct_repeat(oct_repeat), .oct_idle(oct_idle)
    );

    task automatic check_resp(input string tag, input int kind, input logic [7:0] exp);
        logic ok;
        checks++;
        ok = oct_valid && (oct_idle == (kind == K_IDLE)) && (oct_repeat == (kind == K_REP));
        if (kind != K_IDLE && oct_data !== exp) ok = 1'b0;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got valid=%0b rep=%0b idle=%0b data=%02h, expected valid=1 rep=%0b idle=%0b data=%02h",
                     tag, oct_valid, oct_repeat, oct_idle, oct_data,
                     kind == K_REP, kind == K_IDLE, exp);
        end
    endtask

    // ends at a falling edge with the request already registered
    task automatic do_req(input string tag, input int kind, input logic [7:0] exp);
        oct_req = 1'b1;
        @(negedge clk);
        oct_req = 1'b0;
        check_resp(tag, kind, exp);
    endtask

    // starts and ends at a falling edge; ends right after the edge of the last bit
    task automatic send(input bit on_a, input logic [7:0] v, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            if (i != 0) repeat (3) @(negedge clk);
            slot_a = on_a;
            slot_b = !on_a;
            pcm_in = v[7-i];
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
        end
        slot_a = 1'b0;
        slot_b = 1'b0;
        if (nbits < 8) begin
            repeat (3) @(negedge clk);
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a, b;
        repeat (3) @(negedge clk);
        checks++;
        if (oct_valid !== 1'b0 || oct_repeat !== 1'b0 || oct_idle !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset: got valid=%0b rep=%0b idle=%0b, expected 0 0 0",
                     oct_valid, oct_repeat, oct_idle);
        end
        rst_n = 1'b1;
        @(negedge clk);
        do_req("R7 request before any octet", K_IDLE, 8'h00);

        // R1: unselected envelope ignored
        slot_sel = 1'b1;
        send(1'b0, 8'h3C, 8); settle();
        do_req("R1 unselected slot_b ignored", K_IDLE, 8'h00);
        send(1'b1, 8'hA5, 8); settle();
        do_req("R1 R5 slot_a fresh", K_FRESH, 8'hA5);
        do_req("R6 single repeat", K_REP, 8'hA5);
        do_req("R7 idle after repeat", K_IDLE, 8'h00);
        slot_sel = 1'b0;
        send(1'b1, 8'hC3, 8); settle();
        do_req("R1 unselected slot_a ignored", K_IDLE, 8'h00);
        send(1'b0, 8'h5A, 8); settle();
        do_req("R1 slot_b fresh", K_FRESH, 8'h5A);

        // R3: partial window discarded
        send(1'b0, 8'hFF, 5); settle();
        do_req("R3 partial window dropped", K_REP, 8'h5A);
        send(1'b0, 8'h81, 8); settle();
        do_req("R3 count restarted", K_FRESH, 8'h81);

        // R8: overwrite of untransferred octet
        send(1'b0, 8'h11, 8); settle();
        send(1'b0, 8'h22, 8); settle();
        do_req("R8 newer octet wins", K_FRESH, 8'h22);
        do_req("R8 repeat of newer", K_REP, 8'h22);
        do_req("R8 older never sent", K_IDLE, 8'h00);

        // R10: request offset sweep against crossing latency
        for (int k = 1; k <= 7; k++) begin
            a = 8'h40 + 8'(k);
            b = 8'hB0 ^ 8'(k * 3);
            send(1'b0, a, 8); settle();
            do_req("R10 setup fresh", K_FRESH, a);
            send(1'b0, b, 8);
            repeat (k - 1) @(negedge clk);
            if (k < 3) begin
                do_req("R10 early request repeats old", K_REP, a);
                settle();
                do_req("R10 new octet after early", K_FRESH, b);
            end else begin
                do_req("R10 request at or after latch write", K_FRESH, b);
            end
            do_req("R10 R6 repeat new", K_REP, b);
            do_req("R10 R7 idle", K_IDLE, 8'h00);
        end

        // R2 R11: every octet value, alternating envelope
        for (int v = 0; v < 256; v++) begin
            slot_sel = v[0];
            send(v[0], 8'(v), 8); settle();
            do_req("R2 R11 value sweep", K_FRESH, 8'(v));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule